// File: doc/BRIEF.md
# Pulse-Swallow Synthesizer Divider with Lock Qualifier

This block holds the counting logic of a frequency synthesizer built around an external dual-modulus (divide by 64 or 65) prescaler. Each prescaler output event arrives as a one-cycle strobe on `pre_tick_i`. The block drives the modulus-select line back to the prescaler, so one feedback pulse appears for every 64·B + A VCO cycles. In parallel, a reference divider counts strobes from a 12.8 MHz crystal. It produces the comparison pulse at 5 kHz (divide by 2560) or at 6.25 kHz (divide by 2048).

A lock qualifier compares the timing of the two pulses once per reference period. It declares lock only after a run of consecutive good comparisons and drops lock on the first bad one. Transmit enable is the transmit request gated by lock, so the radio cannot key while the loop is unlocked. New divider settings wait in shadow registers and switch in at the next period boundary of the divider they belong to. Any accepted reprogramming forces lock off until lock has been qualified again under the new settings.

Top module: `swallow_synth_ctl`

## Requirements
- R1: While reset is held, and after release before any tick, `locked_o`, `tx_en_o`, `fb_pulse_o`, `ref_pulse_o` and `mod_ctrl_o` are 0. The active settings after reset are A=0, B=2560 and the 5 kHz step.
- R2: `fb_pulse_o` is a one-cycle pulse that follows the `pre_tick_i` strobe completing each run of B strobes, so consecutive pulses are B strobes apart.
- R3: `mod_ctrl_o` is 1 (divide by 65) for the first A strobes of every feedback period and 0 (divide by 64) for the remaining B−A strobes. It changes only after a `pre_tick_i` strobe.
- R4: `ref_pulse_o` pulses once every 2560 `xtal_tick_i` strobes when the active step is 0, and once every 2048 strobes when the step is 1.
- R5: An accepted load does not shorten or lengthen the period in progress. The new A and B take effect from the next feedback boundary, and the new step from the next reference boundary.
- R6: A load with B=0 or with B<A is discarded entirely: divider periods, step and lock state are unchanged.
- R7: `locked_o` rises in the cycle after the 16th consecutive reference period judged good, and not earlier.
- R8: A reference period is good when the feedback pulse falls no more than `lock_win_i` cycles before or after the reference pulse (the bound is inclusive). If no feedback pulse arrives within the window after the reference pulse, `locked_o` drops in the cycle after the window expires.
- R9: `tx_en_o` equals `tx_req_i` AND `locked_o`.
- R10: An accepted load clears `locked_o` and `tx_en_o` from the next cycle. Qualification stays held off until both dividers run on the new settings, and then restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pre_tick_i | input | 1 | One-cycle strobe per prescaler output cycle |
| xtal_tick_i | input | 1 | One-cycle strobe per crystal reference cycle |
| cfg_load_i | input | 1 | Load request for the shadow settings |
| cfg_a_i | input | A_W (6) | Swallow count A |
| cfg_b_i | input | B_W (12) | Main count B |
| cfg_step_i | input | 1 | Channel step: 0 = 5 kHz, 1 = 6.25 kHz |
| lock_win_i | input | WIN_W (8) | Allowed edge distance in clock cycles |
| tx_req_i | input | 1 | Transmit request |
| mod_ctrl_o | output | 1 | Modulus select: 1 = divide by 65, 0 = divide by 64 |
| fb_pulse_o | output | 1 | Feedback comparison pulse |
| ref_pulse_o | output | 1 | Reference comparison pulse |
| locked_o | output | 1 | Loop qualified as locked |
| tx_en_o | output | 1 | Gated transmit enable |

## Verification
The feedback divider is tried with A/B pairs that include A=0 (modulus select never high), A=B (always high), the largest A, and B=1. Measuring both the pulse spacing and the number of divide-by-65 cycles separates an error in the B count from an error in the swallow count. The qualifier is driven with the feedback leading the reference by the full window, then lagging by the full window, then lagging by one cycle more. These cases distinguish an inclusive bound from an exclusive one and exercise each side of the comparison. Loads are placed mid-period so that a setting applied too early shows up as a wrong period length, and rejected loads are issued while locked so that any side effect on lock shows up as a drop.

// File: rtl/swallow_synth_pkg.sv
package swallow_synth_pkg;

    // Outcome of one reference-period comparison
    typedef enum logic [1:0] {
        VERD_NONE = 2'd0,
        VERD_HIT  = 2'd1,
        VERD_MISS = 2'd2
    } verdict_e;

    // Channel step selection for the reference divider
    typedef enum logic {
        STEP_COARSE = 1'b0,   // 5 kHz comparison rate
        STEP_FINE   = 1'b1    // 6.25 kHz comparison rate
    } step_e;

endpackage

// File: rtl/swallow_fb_div.sv
module swallow_fb_div #(
    parameter int A_W   = 6,
    parameter int B_W   = 12,
    parameter int DEF_A = 0,
    parameter int DEF_B = 2560
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick_i,
    input  logic           load_i,
    input  logic [A_W-1:0] a_i,
    input  logic [B_W-1:0] b_i,
    output logic           mod_hi_o,
    output logic           pulse_o,
    output logic           busy_o
);

    typedef struct packed {
        logic [B_W-1:0] cnt;
        logic [A_W-1:0] a_act;
        logic [B_W-1:0] b_act;
        logic [A_W-1:0] a_pend;
        logic [B_W-1:0] b_pend;
        logic           pend;
        logic           pulse;
    } fb_st_t;

    fb_st_t st_d, st_q;
    logic   last_tick;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        last_tick  = (st_q.cnt == st_q.b_act - B_W'(1));

        if (tick_i) begin
            if (last_tick) begin
                // period boundary: restart and swap in staged settings
                st_d.cnt   = '0;
                st_d.pulse = 1'b1;
                if (st_q.pend) begin
                    st_d.a_act = st_q.a_pend;
                    st_d.b_act = st_q.b_pend;
                    st_d.pend  = 1'b0;
                end
            end else begin
                st_d.cnt = st_q.cnt + B_W'(1);
            end
        end

        // a load in the boundary cycle stays staged for the next boundary
        if (load_i) begin
            st_d.a_pend = a_i;
            st_d.b_pend = b_i;
            st_d.pend   = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{cnt:    '0,
                      a_act:  A_W'(DEF_A),
                      b_act:  B_W'(DEF_B),
                      a_pend: A_W'(DEF_A),
                      b_pend: B_W'(DEF_B),
                      pend:   1'b0,
                      pulse:  1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign mod_hi_o = (st_q.cnt < B_W'(st_q.a_act));
    assign pulse_o  = st_q.pulse;
    assign busy_o   = st_q.pend;

endmodule

// File: rtl/xtal_ref_div.sv
module xtal_ref_div
    import swallow_synth_pkg::*;
#(
    parameter int R_SLOW = 2560,
    parameter int R_FAST = 2048
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic load_i,
    input  logic step_i,
    output logic pulse_o,
    output logic busy_o
);

    localparam int R_MAX = (R_SLOW > R_FAST) ? R_SLOW : R_FAST;
    localparam int R_W   = $clog2(R_MAX + 1);

    typedef struct packed {
        logic [R_W-1:0] cnt;
        step_e          step_act;
        step_e          step_pend;
        logic           pend;
        logic           pulse;
    } ref_st_t;

    ref_st_t        st_d, st_q;
    logic [R_W-1:0] limit;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        limit      = (st_q.step_act == STEP_FINE) ? R_W'(R_FAST - 1) : R_W'(R_SLOW - 1);

        if (tick_i) begin
            if (st_q.cnt == limit) begin
                st_d.cnt   = '0;
                st_d.pulse = 1'b1;
                if (st_q.pend) begin
                    st_d.step_act = st_q.step_pend;
                    st_d.pend     = 1'b0;
                end
            end else begin
                st_d.cnt = st_q.cnt + R_W'(1);
            end
        end

        if (load_i) begin
            st_d.step_pend = step_e'(step_i);
            st_d.pend      = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{cnt:       '0,
                      step_act:  STEP_COARSE,
                      step_pend: STEP_COARSE,
                      pend:      1'b0,
                      pulse:     1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse_o = st_q.pulse;
    assign busy_o  = st_q.pend;

endmodule

// File: rtl/phase_lock_qual.sv
module phase_lock_qual
    import swallow_synth_pkg::*;
#(
    parameter int WIN_W = 8,
    parameter int RUNS  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_pulse_i,
    input  logic             fb_pulse_i,
    input  logic [WIN_W-1:0] win_i,
    input  logic             clear_i,
    output logic             locked_o
);

    localparam int AGE_W = WIN_W + 1;
    localparam int H_W   = $clog2(RUNS + 1);

    typedef struct packed {
        logic [AGE_W-1:0] ref_age;   // cycles since the last reference pulse
        logic [AGE_W-1:0] fb_age;    // cycles since the last feedback pulse
        logic             waiting;   // reference seen, feedback still due
        logic [H_W-1:0]   hits;
        logic             locked;
    } lq_st_t;

    lq_st_t           st_d, st_q;
    verdict_e         verdict;
    logic [AGE_W-1:0] win_x;
    logic [AGE_W-1:0] fb_dist;

    always_comb begin
        st_d    = st_q;
        verdict = VERD_NONE;
        win_x   = {1'b0, win_i};
        fb_dist = fb_pulse_i ? '0 : st_q.fb_age;

        // saturating age trackers
        st_d.fb_age  = fb_pulse_i  ? AGE_W'(1) :
                       (&st_q.fb_age)  ? st_q.fb_age  : st_q.fb_age  + AGE_W'(1);
        st_d.ref_age = ref_pulse_i ? AGE_W'(1) :
                       (&st_q.ref_age) ? st_q.ref_age : st_q.ref_age + AGE_W'(1);

        if (ref_pulse_i) begin
            // feedback already arrived (or arrives now) close enough
            if (fb_dist <= win_x) begin
                verdict = VERD_HIT;
            end
            st_d.waiting = (fb_dist > win_x);
        end else if (st_q.waiting) begin
            if (fb_pulse_i && (st_q.ref_age <= win_x)) begin
                verdict      = VERD_HIT;
                st_d.waiting = 1'b0;
            end else if (st_q.ref_age > win_x) begin
                verdict      = VERD_MISS;
                st_d.waiting = 1'b0;
            end
        end

        case (verdict)
            VERD_HIT: begin
                if (st_q.hits != H_W'(RUNS)) begin
                    st_d.hits = st_q.hits + H_W'(1);
                end
                if (st_q.hits >= H_W'(RUNS - 1)) begin
                    st_d.locked = 1'b1;
                end
            end
            VERD_MISS: begin
                st_d.hits   = '0;
                st_d.locked = 1'b0;
            end
            default: ;
        endcase

        if (clear_i) begin
            st_d.hits    = '0;
            st_d.locked  = 1'b0;
            st_d.waiting = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{ref_age: '1,
                      fb_age:  '1,
                      waiting: 1'b0,
                      hits:    '0,
                      locked:  1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign locked_o = st_q.locked;

endmodule

// File: rtl/swallow_synth_ctl.sv
module swallow_synth_ctl #(
    parameter int A_W       = 6,
    parameter int B_W       = 12,
    parameter int DEF_A     = 0,
    parameter int DEF_B     = 2560,
    parameter int REF_SLOW  = 2560,
    parameter int REF_FAST  = 2048,
    parameter int WIN_W     = 8,
    parameter int LOCK_RUNS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pre_tick_i,
    input  logic             xtal_tick_i,
    input  logic             cfg_load_i,
    input  logic [A_W-1:0]   cfg_a_i,
    input  logic [B_W-1:0]   cfg_b_i,
    input  logic             cfg_step_i,
    input  logic [WIN_W-1:0] lock_win_i,
    input  logic             tx_req_i,
    output logic             mod_ctrl_o,
    output logic             fb_pulse_o,
    output logic             ref_pulse_o,
    output logic             locked_o,
    output logic             tx_en_o
);

    logic accept;
    logic fb_busy;
    logic ref_busy;
    logic qual_clear;

    // a setting is usable only when the main count covers the swallow count
    assign accept     = cfg_load_i && (cfg_b_i != '0) && (cfg_b_i >= B_W'(cfg_a_i));
    assign qual_clear = accept || fb_busy || ref_busy;

    swallow_fb_div #(
        .A_W   (A_W),
        .B_W   (B_W),
        .DEF_A (DEF_A),
        .DEF_B (DEF_B)
    ) u_fb (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (pre_tick_i),
        .load_i   (accept),
        .a_i      (cfg_a_i),
        .b_i      (cfg_b_i),
        .mod_hi_o (mod_ctrl_o),
        .pulse_o  (fb_pulse_o),
        .busy_o   (fb_busy)
    );

    xtal_ref_div #(
        .R_SLOW (REF_SLOW),
        .R_FAST (REF_FAST)
    ) u_ref (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (xtal_tick_i),
        .load_i  (accept),
        .step_i  (cfg_step_i),
        .pulse_o (ref_pulse_o),
        .busy_o  (ref_busy)
    );

    phase_lock_qual #(
        .WIN_W (WIN_W),
        .RUNS  (LOCK_RUNS)
    ) u_lock (
        .clk         (clk),
        .rst_n       (rst_n),
        .ref_pulse_i (ref_pulse_o),
        .fb_pulse_i  (fb_pulse_o),
        .win_i       (lock_win_i),
        .clear_i     (qual_clear),
        .locked_o    (locked_o)
    );

    assign tx_en_o = tx_req_i && locked_o;

endmodule

// File: rtl/swallow_synth_ctl_chk.sv
module swallow_synth_ctl_chk #(
    parameter int A_W = 6,
    parameter int B_W = 12
) (
    input logic           clk,
    input logic           rst_n,
    input logic           pre_tick_i,
    input logic           xtal_tick_i,
    input logic           cfg_load_i,
    input logic [A_W-1:0] cfg_a_i,
    input logic [B_W-1:0] cfg_b_i,
    input logic           mod_ctrl_o,
    input logic           fb_pulse_o,
    input logic           ref_pulse_o,
    input logic           locked_o,
    input logic           tx_en_o
);

    // R2: a feedback pulse always follows a prescaler strobe
    p_fb_after_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fb_pulse_o |-> $past(pre_tick_i));

    // R3: modulus select moves only on prescaler strobes
    p_mod_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !pre_tick_i |=> $stable(mod_ctrl_o));

    // R4: reference pulse follows a crystal strobe and is one cycle wide
    p_ref_after_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ref_pulse_o |-> $past(xtal_tick_i));

    p_ref_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ref_pulse_o |=> !ref_pulse_o);

    // R7: lock can only be won on a comparison event
    p_lock_on_event_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked_o) |-> $past(ref_pulse_o || fb_pulse_o));

    // R10: accepted load removes lock and transmit enable next cycle
    p_unlock_on_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_load_i && (cfg_b_i != '0) && (cfg_b_i >= B_W'(cfg_a_i)))
        |=> (!locked_o && !tx_en_o));

endmodule

bind swallow_synth_ctl swallow_synth_ctl_chk #(
    .A_W (A_W),
    .B_W (B_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pre_tick_i  (pre_tick_i),
    .xtal_tick_i (xtal_tick_i),
    .cfg_load_i  (cfg_load_i),
    .cfg_a_i     (cfg_a_i),
    .cfg_b_i     (cfg_b_i),
    .mod_ctrl_o  (mod_ctrl_o),
    .fb_pulse_o  (fb_pulse_o),
    .ref_pulse_o (ref_pulse_o),
    .locked_o    (locked_o),
    .tx_en_o     (tx_en_o)
);

// File: tb/sim_swallow_synth_ctl.sv
`timescale 1ns/1ps
module sim_swallow_synth_ctl;

    localparam int A_W   = 6;
    localparam int B_W   = 12;
    localparam int WIN_W = 8;
    localparam int WIN   = 4;

    // table: swallow count, main count, expected spacing, expected /65 cycles
    localparam int N_VEC = 4;
    localparam int VEC_A   [N_VEC] = '{0, 5, 63, 1};
    localparam int VEC_B   [N_VEC] = '{7, 5, 70, 1};
    localparam int EXP_GAP [N_VEC] = '{7, 5, 70, 1};
    localparam int EXP_MOD [N_VEC] = '{0, 5, 63, 1};

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             pre_tick_i = 1'b0;
    logic             xtal_tick_i = 1'b0;
    logic             cfg_load_i = 1'b0;
    logic [A_W-1:0]   cfg_a_i = '0;
    logic [B_W-1:0]   cfg_b_i = '0;
    logic             cfg_step_i = 1'b0;
    logic [WIN_W-1:0] lock_win_i = WIN_W'(WIN);
    logic             tx_req_i = 1'b0;
    logic             mod_ctrl_o, fb_pulse_o, ref_pulse_o, locked_o, tx_en_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;
    int t0, t1, t2, gap, mh;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    swallow_synth_ctl u0 (
        .clk(clk), .rst_n(rst_n), .pre_tick_i(pre_tick_i), .xtal_tick_i(xtal_tick_i),
        .cfg_load_i(cfg_load_i), .cfg_a_i(cfg_a_i), .cfg_b_i(cfg_b_i),
        .cfg_step_i(cfg_step_i), .lock_win_i(lock_win_i), .tx_req_i(tx_req_i),
        .mod_ctrl_o(mod_ctrl_o), .fb_pulse_o(fb_pulse_o), .ref_pulse_o(ref_pulse_o),
        .locked_o(locked_o), .tx_en_o(tx_en_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_ref(output int t);
        @(negedge clk);
        while (!ref_pulse_o) @(negedge clk);
        t = cyc;
    endtask

    task automatic wait_fb(output int t);
        @(negedge clk);
        while (!fb_pulse_o) @(negedge clk);
        t = cyc;
    endtask

    // called at a feedback pulse; stops at the next one
    task automatic measure_fb(output int g, output int m);
        g = 0;
        m = 0;
        do begin
            if (mod_ctrl_o) m++;
            g++;
            @(negedge clk);
        end while (!fb_pulse_o);
    endtask

    task automatic load(input int a, input int b, input int s);
        cfg_a_i    = A_W'(a);
        cfg_b_i    = B_W'(b);
        cfg_step_i = s[0];
        cfg_load_i = 1'b1;
        @(negedge clk);
        cfg_load_i = 1'b0;
    endtask

    task automatic hold_pre(input int n);
        pre_tick_i = 1'b0;
        repeat (n) @(negedge clk);
        pre_tick_i = 1'b1;
    endtask

    task automatic hold_xtal(input int n);
        xtal_tick_i = 1'b0;
        repeat (n) @(negedge clk);
        xtal_tick_i = 1'b1;
    endtask

    // counts 16 reference pulses; lock must appear only after the last
    task automatic qualify(input string tag);
        int t;
        for (int i = 0; i < 15; i++) wait_ref(t);
        chk({tag, " no lock after 15 periods"}, int'(locked_o), 0);
        wait_ref(t);
        chk({tag, " no lock in 16th pulse cycle"}, int'(locked_o), 0);
        @(negedge clk);
        chk({tag, " lock after 16 periods"}, int'(locked_o), 1);
    endtask

    initial begin
        // R1: reset state
        repeat (4) @(negedge clk);
        chk("R1 locked in reset", int'(locked_o), 0);
        chk("R1 fb pulse in reset", int'(fb_pulse_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 locked after reset", int'(locked_o), 0);
        chk("R1 tx_en after reset", int'(tx_en_o), 0);
        chk("R1 ref pulse idle", int'(ref_pulse_o), 0);
        chk("R1 mod_ctrl with A=0", int'(mod_ctrl_o), 0);

        // R7/R2/R4: aligned defaults lock after 16 periods
        tx_req_i    = 1'b1;
        pre_tick_i  = 1'b1;
        xtal_tick_i = 1'b1;
        wait_ref(t0);
        chk("R2 fb coincident with first ref", int'(fb_pulse_o), 1);
        chk("R9 tx_en low while unlocked", int'(tx_en_o), 0);
        wait_ref(t1);
        chk("R4 ref spacing step 0", t1 - t0, 2560);
        chk("R2 fb spacing B=2560", int'(fb_pulse_o), 1);
        for (int i = 0; i < 13; i++) wait_ref(t1);
        chk("R7 no lock after 15 periods", int'(locked_o), 0);
        wait_ref(t1);
        @(negedge clk);
        chk("R7 lock after 16 periods", int'(locked_o), 1);

        // R9: gating
        chk("R9 tx_en with request and lock", int'(tx_en_o), 1);
        tx_req_i = 1'b0;
        @(negedge clk);
        chk("R9 tx_en without request", int'(tx_en_o), 0);
        tx_req_i = 1'b1;

        // R6: rejected loads leave everything untouched
        load(5, 2, 0);
        chk("R6 B<A keeps lock", int'(locked_o), 1);
        load(0, 0, 1);
        chk("R6 B=0 keeps lock", int'(locked_o), 1);
        wait_ref(t1);
        wait_ref(t2);
        chk("R6 ref spacing unchanged", t2 - t1, 2560);
        chk("R6 fb still aligned", int'(fb_pulse_o), 1);
        @(negedge clk);
        chk("R6 still locked", int'(locked_o), 1);

        // R10: accepted load drops lock, qualification restarts
        repeat (100) @(negedge clk);
        load(0, 2560, 0);
        chk("R10 lock cleared after load", int'(locked_o), 0);
        chk("R10 tx_en cleared after load", int'(tx_en_o), 0);
        qualify("R10");

        // R8: feedback leads by the full window
        repeat (100) @(negedge clk);
        hold_xtal(WIN);
        wait_ref(t1);
        wait_ref(t1);
        repeat (WIN + 2) @(negedge clk);
        chk("R8 lead of window keeps lock", int'(locked_o), 1);
        // R8: feedback lags by the full window
        hold_pre(2 * WIN);
        wait_ref(t1);
        wait_ref(t1);
        repeat (WIN + 2) @(negedge clk);
        chk("R8 lag of window keeps lock", int'(locked_o), 1);
        // R8: one cycle beyond the window
        hold_pre(1);
        wait_ref(t1);
        repeat (WIN + 1) @(negedge clk);
        chk("R8 lock held until window expires", int'(locked_o), 1);
        @(negedge clk);
        chk("R8 lock dropped after miss", int'(locked_o), 0);

        // R5: load mid-period, old spacing finishes first
        wait_fb(t0);
        repeat (100) @(negedge clk);
        load(3, 10, 0);
        wait_fb(t1);
        chk("R5 period in progress keeps B=2560", t1 - t0, 2560);
        measure_fb(gap, mh);
        chk("R2 new spacing B=10", gap, 10);
        chk("R3 divide-by-65 cycles A=3", mh, 3);

        // R2/R3: table of swallow/main settings
        for (int v = 0; v < N_VEC; v++) begin
            load(VEC_A[v], VEC_B[v], 0);
            wait_fb(t1);
            measure_fb(gap, mh);
            chk($sformatf("R2 spacing vector %0d", v), gap, EXP_GAP[v]);
            chk($sformatf("R3 mod count vector %0d", v), mh, EXP_MOD[v]);
        end

        // R4/R5: step change at reference boundary
        wait_ref(t0);
        repeat (50) @(negedge clk);
        load(1, 1, 1);
        wait_ref(t1);
        chk("R5 ref period in progress stays 2560", t1 - t0, 2560);
        wait_ref(t2);
        chk("R4 ref spacing step 1", t2 - t1, 2048);
        repeat (50) @(negedge clk);
        load(1, 1, 0);
        wait_ref(t1);
        chk("R5 ref period in progress stays 2048", t1 - t2, 2048);
        wait_ref(t2);
        chk("R4 ref spacing back to step 0", t2 - t1, 2560);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule